// File: doc/BRIEF.md
# Parallel EEPROM Write-and-Poll Sequencer

This block sits on the host side of an asynchronous 2K x 8 parallel EEPROM. It accepts one command at a time over a valid/ready interface and turns it into a cycle-timed strobe sequence on the memory pins. There are three operations: a byte read, a byte write that completes by data polling, and a whole-array clear that uses an external high-voltage switch. Every setup, pulse, hold and float interval is a parameter in nanoseconds. The block converts each one to clock cycles, rounding up.

A byte write drives the address, data and strobes within their timing margins. It then reads the same address again and again until bit 7 of the returned byte equals bit 7 of the written byte. If that does not happen within a programmable timeout, the command ends with an error flag.

A clear holds chip enable low and asks the external switch to raise the output-enable line to the high voltage. It then gives one long write-enable pulse, with setup and hold time around it. Each command ends with a one-cycle response that carries read data and an error bit.

Top module: `eeprom_seq`

## Requirements
- R1: After reset, `cmd_ready` is 1, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, and `mem_dq_oe`, `mem_hv_req` and `rsp_valid` are 0.
- R2: A read (`cmd_op` = 2'b00) holds CE and OE low for N_RD cycles and then releases them for N_FLT cycles. The response follows exactly N_RD+N_FLT cycles after the accepting edge and carries the byte stored at the address, with `rsp_err` = 0. N_RD is the larger of ceil(address access / period) and ceil(OE access / period). N_FLT is ceil(float time / period).
- R3: In a byte write (`cmd_op` = 2'b01), CE is low and OE is high for at least N_AS cycles before WE falls. WE then stays low for exactly N_WP cycles. CE, OE-high, address and data then hold for at least N_H cycles after WE rises.
- R4: The data bus is driven only while OE is high, and only during the write strobe phases.
- R5: After the write strobe, the block reads the written address repeatedly, at least twice when the memory stays busy for several poll periods. It completes with `rsp_err` = 0 and `rsp_rdata` equal to the written byte once bit 7 matches. The stored byte then reads back.
- R6: If bit 7 has not matched within N_TO cycles of the start of polling, the write completes with `rsp_err` = 1, no earlier than N_TO cycles after acceptance.
- R7: A clear (`cmd_op` = 2'b10) asserts `mem_hv_req` with CE low and OE high. It holds N_CS cycles before WE falls, keeps WE low for N_CW cycles, and holds N_CS cycles after WE rises. It responds exactly 2*N_CS+N_CW cycles after acceptance with `rsp_err` = 0, and every location then reads 8'hFF.
- R8: `cmd_ready` is low from the accepting edge until the response. A command offered during that time is ignored and leaves memory unchanged.
- R9: `rsp_valid` is a single-cycle pulse.
- R10: The reserved code (`cmd_op` = 2'b11) responds in the cycle after acceptance with `rsp_err` = 1 and toggles no memory strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command accepted on this edge if valid |
| cmd_op | input | 2 | 00 read, 01 write, 10 clear, 11 reserved |
| cmd_addr | input | ADDR_W | Byte address |
| cmd_wdata | input | DATA_W | Byte to write |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read byte, or final polled byte of a write |
| rsp_err | output | 1 | Poll timeout or reserved code |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_dq_o | output | DATA_W | Data to memory |
| mem_dq_oe | output | 1 | Data driver enable |
| mem_dq_i | input | DATA_W | Data from memory |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_hv_req | output | 1 | Request to switch OE to the high voltage |

## Verification
The bench counts edges from the one that accepts a command, sampling at the falling edge in between. A read must answer after exactly N_RD+N_FLT edges, a clear after exactly 2*N_CS+N_CW, and a reserved code on the very next one. A write's completion time depends on how long the memory model stays busy, so its checks are of a different kind. The bench checks the strobe intervals the model measured, the polled byte, the number of poll reads, and a lower bound for the timeout case. The falling edge after each response must show `rsp_valid` low.

// File: rtl/eeprom_seq_pkg.sv
package eeprom_seq_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_WRITE = 2'b01,
        OP_CLEAR = 2'b10,
        OP_RSVD  = 2'b11
    } op_e;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_RD_ACC,
        PH_RD_FLT,
        PH_WR_SET,
        PH_WR_PUL,
        PH_WR_HLD,
        PH_PL_ACC,
        PH_PL_FLT,
        PH_CL_SET,
        PH_CL_PUL,
        PH_CL_HLD,
        PH_RESP
    } phase_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic dq_oe;
        logic hv_req;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0, hv_req: 1'b0};

    // Nanoseconds to whole cycles, rounded up, never below one.
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic strobe_t strobe_of(input phase_e ph);
        strobe_t s;
        s = STROBE_IDLE;
        case (ph)
            PH_RD_ACC, PH_PL_ACC: begin
                s.ce_n = 1'b0;
                s.oe_n = 1'b0;
            end
            PH_WR_SET, PH_WR_HLD: begin
                s.ce_n  = 1'b0;
                s.dq_oe = 1'b1;
            end
            PH_WR_PUL: begin
                s.ce_n  = 1'b0;
                s.we_n  = 1'b0;
                s.dq_oe = 1'b1;
            end
            PH_CL_SET, PH_CL_HLD: begin
                s.ce_n   = 1'b0;
                s.hv_req = 1'b1;
            end
            PH_CL_PUL: begin
                s.ce_n   = 1'b0;
                s.we_n   = 1'b0;
                s.hv_req = 1'b1;
            end
            default: s = STROBE_IDLE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/eeprom_seq_timer.sv
module eeprom_seq_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)               cnt_q <= '0;
        else if (load)         cnt_q <= val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/eeprom_seq_pins.sv
module eeprom_seq_pins
    import eeprom_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  phase_e ph_d,
    output logic   mem_ce_n,
    output logic   mem_oe_n,
    output logic   mem_we_n,
    output logic   mem_dq_oe,
    output logic   mem_hv_req
);
    // Strobes come from flops fed by the next phase, so pins never glitch
    // and still change on the same edge as the phase register.
    strobe_t st_q;

    always_ff @(posedge clk) begin
        if (rst) st_q <= STROBE_IDLE;
        else     st_q <= strobe_of(ph_d);
    end

    assign mem_ce_n   = st_q.ce_n;
    assign mem_oe_n   = st_q.oe_n;
    assign mem_we_n   = st_q.we_n;
    assign mem_dq_oe  = st_q.dq_oe;
    assign mem_hv_req = st_q.hv_req;

    // R4
    dq_oe_only_oe_high_chk: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> mem_oe_n);

    // R7
    hv_with_ce_low_chk: assert property (@(posedge clk) disable iff (rst)
        mem_hv_req |-> (!mem_ce_n && mem_oe_n));

    // R3
    we_fall_ctx_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_we_n) |-> (!mem_ce_n && mem_oe_n));

    // R3
    we_rise_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |=> !mem_ce_n);

endmodule

// File: rtl/eeprom_seq_ctl.sv
module eeprom_seq_ctl
    import eeprom_seq_pkg::*;
#(
    parameter int unsigned ADDR_W = 11,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CW     = 8,
    parameter int unsigned PW     = 8,
    parameter int unsigned N_RD   = 30,
    parameter int unsigned N_FLT  = 10,
    parameter int unsigned N_AS   = 2,
    parameter int unsigned N_WP   = 20,
    parameter int unsigned N_H    = 10,
    parameter int unsigned N_CS   = 200,
    parameter int unsigned N_CW   = 200,
    parameter int unsigned N_TO   = 200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_o,
    input  logic [DATA_W-1:0] mem_dq_i,
    output phase_e            ph_d,
    output logic              t_load,
    output logic [CW-1:0]     t_val,
    input  logic              t_zero,
    output logic              p_load,
    output logic [PW-1:0]     p_val,
    input  logic              p_zero
);
    localparam int unsigned MSB = DATA_W - 1;

    phase_e            ph_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              err_q;
    logic              match_q;
    logic              accept;
    logic              capture;

    assign accept  = (ph_q == PH_IDLE) && cmd_valid;
    assign capture = t_zero && ((ph_q == PH_RD_ACC) || (ph_q == PH_PL_ACC));

    always_comb begin
        ph_d   = ph_q;
        t_load = 1'b0;
        t_val  = '0;
        p_load = 1'b0;
        p_val  = PW'(N_TO - 1);
        case (ph_q)
            PH_IDLE: if (cmd_valid) begin
                t_load = 1'b1;
                case (op_e'(cmd_op))
                    OP_READ:  begin ph_d = PH_RD_ACC; t_val = CW'(N_RD - 1); end
                    OP_WRITE: begin ph_d = PH_WR_SET; t_val = CW'(N_AS - 1); end
                    OP_CLEAR: begin ph_d = PH_CL_SET; t_val = CW'(N_CS - 1); end
                    default:  begin ph_d = PH_RESP;   t_load = 1'b0;          end
                endcase
            end
            PH_RD_ACC: if (t_zero) begin ph_d = PH_RD_FLT; t_load = 1'b1; t_val = CW'(N_FLT - 1); end
            PH_RD_FLT: if (t_zero) ph_d = PH_RESP;
            PH_WR_SET: if (t_zero) begin ph_d = PH_WR_PUL; t_load = 1'b1; t_val = CW'(N_WP - 1); end
            PH_WR_PUL: if (t_zero) begin ph_d = PH_WR_HLD; t_load = 1'b1; t_val = CW'(N_H - 1); end
            PH_WR_HLD: if (t_zero) begin
                ph_d   = PH_PL_ACC;
                t_load = 1'b1;
                t_val  = CW'(N_RD - 1);
                p_load = 1'b1;
            end
            PH_PL_ACC: if (t_zero) begin ph_d = PH_PL_FLT; t_load = 1'b1; t_val = CW'(N_FLT - 1); end
            PH_PL_FLT: if (t_zero) begin
                if (match_q || p_zero) begin
                    ph_d = PH_RESP;
                end else begin
                    ph_d   = PH_PL_ACC;
                    t_load = 1'b1;
                    t_val  = CW'(N_RD - 1);
                end
            end
            PH_CL_SET: if (t_zero) begin ph_d = PH_CL_PUL; t_load = 1'b1; t_val = CW'(N_CW - 1); end
            PH_CL_PUL: if (t_zero) begin ph_d = PH_CL_HLD; t_load = 1'b1; t_val = CW'(N_CS - 1); end
            PH_CL_HLD: if (t_zero) ph_d = PH_RESP;
            PH_RESP:   ph_d = PH_IDLE;
            default:   ph_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q    <= PH_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            err_q   <= 1'b0;
            match_q <= 1'b0;
        end else begin
            ph_q <= ph_d;
            if (accept) begin
                addr_q  <= cmd_addr;
                wdata_q <= cmd_wdata;
                rdata_q <= '0;
                err_q   <= (op_e'(cmd_op) == OP_RSVD);
                match_q <= 1'b0;
            end
            if (capture) begin
                rdata_q <= mem_dq_i;
                match_q <= (mem_dq_i[MSB] == wdata_q[MSB]);
            end
            if (ph_q == PH_PL_FLT && t_zero && !match_q && p_zero)
                err_q <= 1'b1;
        end
    end

    assign cmd_ready = (ph_q == PH_IDLE);
    assign rsp_valid = (ph_q == PH_RESP);
    assign rsp_rdata = rdata_q;
    assign rsp_err   = err_q;
    assign mem_addr  = addr_q;
    assign mem_dq_o  = wdata_q;

    // R8
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    // R9
    rsp_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    // R3
    addr_stable_in_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_WR_PUL) |=> $stable(mem_addr));

    // R5
    poll_ok_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_err && $past(ph_q) == PH_PL_FLT) |-> (rsp_rdata[MSB] == wdata_q[MSB]));

endmodule

// File: rtl/eeprom_seq.sv
module eeprom_seq
    import eeprom_seq_pkg::*;
#(
    parameter int unsigned ADDR_W          = 11,
    parameter int unsigned DATA_W          = 8,
    parameter int unsigned CLK_PERIOD_NS   = 5,
    parameter int unsigned T_ADDR_ACC_NS   = 150,
    parameter int unsigned T_OE_ACC_NS     = 70,
    parameter int unsigned T_FLOAT_NS      = 50,
    parameter int unsigned T_ADDR_SU_NS    = 10,
    parameter int unsigned T_ADDR_HD_NS    = 50,
    parameter int unsigned T_DATA_SU_NS    = 50,
    parameter int unsigned T_DATA_HD_NS    = 10,
    parameter int unsigned T_WE_LOW_NS     = 100,
    parameter int unsigned T_WE_HIGH_NS    = 50,
    parameter int unsigned T_OE_SU_NS      = 10,
    parameter int unsigned T_OE_HD_NS      = 10,
    parameter int unsigned T_HV_EDGE_NS    = 1000,
    parameter int unsigned T_CLR_PULSE_NS  = 10_000_000,
    parameter int unsigned POLL_TIMEOUT_NS = 1_100_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_hv_req
);
    localparam int unsigned N_RD  = max2(ns_to_cyc(T_ADDR_ACC_NS, CLK_PERIOD_NS),
                                         ns_to_cyc(T_OE_ACC_NS, CLK_PERIOD_NS));
    localparam int unsigned N_FLT = ns_to_cyc(T_FLOAT_NS, CLK_PERIOD_NS);
    localparam int unsigned N_AS  = max2(ns_to_cyc(T_ADDR_SU_NS, CLK_PERIOD_NS),
                                         ns_to_cyc(T_OE_SU_NS, CLK_PERIOD_NS));
    localparam int unsigned N_WP  = max2(ns_to_cyc(T_WE_LOW_NS, CLK_PERIOD_NS),
                                         ns_to_cyc(T_DATA_SU_NS, CLK_PERIOD_NS));
    localparam int unsigned N_H   = max2(max2(ns_to_cyc(T_ADDR_HD_NS, CLK_PERIOD_NS),
                                              ns_to_cyc(T_DATA_HD_NS, CLK_PERIOD_NS)),
                                         max2(ns_to_cyc(T_OE_HD_NS, CLK_PERIOD_NS),
                                              ns_to_cyc(T_WE_HIGH_NS, CLK_PERIOD_NS)));
    localparam int unsigned N_CS  = ns_to_cyc(T_HV_EDGE_NS, CLK_PERIOD_NS);
    localparam int unsigned N_CW  = ns_to_cyc(T_CLR_PULSE_NS, CLK_PERIOD_NS);
    localparam int unsigned N_TO  = ns_to_cyc(POLL_TIMEOUT_NS, CLK_PERIOD_NS);
    localparam int unsigned N_MAX = max2(max2(max2(N_RD, N_FLT), max2(N_AS, N_WP)),
                                         max2(N_H, max2(N_CS, N_CW)));
    localparam int unsigned CW    = $clog2(N_MAX + 1);
    localparam int unsigned PW    = $clog2(N_TO + 1);

    phase_e        ph_d;
    logic          t_load, t_zero, p_load, p_zero;
    logic [CW-1:0] t_val;
    logic [PW-1:0] p_val;

    eeprom_seq_timer #(.W(CW)) u_phase_tmr (
        .clk(clk), .rst(rst), .load(t_load), .val(t_val), .zero(t_zero)
    );

    eeprom_seq_timer #(.W(PW)) u_poll_tmr (
        .clk(clk), .rst(rst), .load(p_load), .val(p_val), .zero(p_zero)
    );

    eeprom_seq_ctl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CW(CW), .PW(PW),
        .N_RD(N_RD), .N_FLT(N_FLT), .N_AS(N_AS), .N_WP(N_WP), .N_H(N_H),
        .N_CS(N_CS), .N_CW(N_CW), .N_TO(N_TO)
    ) u_ctl (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_i(mem_dq_i),
        .ph_d(ph_d),
        .t_load(t_load), .t_val(t_val), .t_zero(t_zero),
        .p_load(p_load), .p_val(p_val), .p_zero(p_zero)
    );

    eeprom_seq_pins u_pins (
        .clk(clk), .rst(rst), .ph_d(ph_d),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_dq_oe(mem_dq_oe), .mem_hv_req(mem_hv_req)
    );

    // R1
    idle_strobes_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_ready && !$past(rsp_valid)) |-> (mem_ce_n && mem_we_n && !mem_hv_req));

endmodule

// File: tb/eeprom_seq_bench.sv
module eeprom_seq_bench;
    localparam int CLK_NS   = 5;
    localparam int CLR_NS   = 2000;
    localparam int POLL_NS  = 10000;
    localparam int BUSY_CYC = 300;

    function automatic int cyc(input int ns);
        int c;
        c = (ns + CLK_NS - 1) / CLK_NS;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int N_RD  = 30;             // max(150 ns, 70 ns) at 5 ns
    localparam int N_FLT = 10;             // 50 ns
    localparam int N_AS  = 2;              // 10 ns
    localparam int N_WP  = 20;             // 100 ns
    localparam int N_H   = 10;             // 50 ns
    localparam int N_CS  = 200;            // 1000 ns
    int n_cw, n_to;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [1:0]  cmd_op = 2'b00;
    logic [10:0] cmd_addr = '0;
    logic [7:0]  cmd_wdata = '0;
    logic        rsp_valid, rsp_err;
    logic [7:0]  rsp_rdata;
    logic [10:0] mem_addr;
    logic [7:0]  mem_dq_o, mem_dq_i;
    logic        mem_dq_oe, mem_ce_n, mem_oe_n, mem_we_n, mem_hv_req;

    always #2.5 clk = ~clk;

    eeprom_seq #(.CLK_PERIOD_NS(CLK_NS), .T_CLR_PULSE_NS(CLR_NS), .POLL_TIMEOUT_NS(POLL_NS)) u_eeprom_seq (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
        .mem_dq_i(mem_dq_i), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_hv_req(mem_hv_req)
    );

    // ---------------- memory model ----------------
    logic [7:0]  mem [2048];
    int          busy_cnt, stuck;
    logic [10:0] busy_addr;
    logic [7:0]  busy_data;
    logic        prev_ce, prev_we, prev_oe, after_we;
    int          pre_cnt, post_cnt, low_cnt;
    int          last_setup, last_low, last_hold, n_reads, n_ce_falls, viol, dq_seen;
    logic        hv_at_fall;

    always_comb begin
        if (!mem_ce_n && !mem_oe_n) begin
            if (busy_cnt > 0 && mem_addr == busy_addr)
                mem_dq_i = {~busy_data[7], busy_data[6:0]};
            else
                mem_dq_i = mem[mem_addr];
        end else begin
            mem_dq_i = 8'hEE;
        end
    end

    always @(negedge clk) begin
        if (rst) begin
            for (int i = 0; i < 2048; i++) mem[i] = 8'(i) ^ 8'h5A;
            busy_cnt = 0; prev_ce = 1; prev_we = 1; prev_oe = 1; after_we = 0;
            pre_cnt = 0; post_cnt = 0; low_cnt = 0; last_setup = 0; last_low = 0;
            last_hold = 0; n_reads = 0; n_ce_falls = 0; viol = 0; dq_seen = 0; hv_at_fall = 0;
        end else begin
            if (busy_cnt > 0 && stuck == 0) begin
                if (busy_cnt == 1) mem[busy_addr] = busy_data;
                busy_cnt--;
            end
            if (mem_dq_oe && !mem_oe_n) viol++;
            if (mem_dq_oe) dq_seen++;
            if (!mem_oe_n && prev_oe) n_reads++;
            if (!mem_ce_n && prev_ce) n_ce_falls++;
            if (mem_ce_n) begin
                if (after_we) last_hold = post_cnt;
                pre_cnt = 0; post_cnt = 0; after_we = 0;
            end else if (mem_we_n) begin
                if (!prev_we) begin
                    last_low = low_cnt;
                    after_we = 1;
                    if (mem_hv_req)
                        for (int i = 0; i < 2048; i++) mem[i] = 8'hFF;
                    else begin
                        busy_addr = mem_addr; busy_data = mem_dq_o; busy_cnt = BUSY_CYC;
                    end
                end
                if (after_we) begin
                    if (!mem_oe_n) begin last_hold = post_cnt; after_we = 0; end
                    else post_cnt++;
                end else begin
                    if (mem_oe_n) pre_cnt++; else pre_cnt = 0;
                end
            end else begin
                if (prev_we) begin last_setup = pre_cnt; hv_at_fall = mem_hv_req; low_cnt = 1; end
                else low_cnt++;
            end
            prev_ce = mem_ce_n; prev_we = mem_we_n; prev_oe = mem_oe_n;
        end
    end

    // ---------------- checking ----------------
    int checks = 0, errors = 0;
    bit finished = 0;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_ge(input string req, input int act, input int lo);
        checks++;
        if (act < lo) begin
            errors++;
            $display("FAIL %s actual=%0d expected>=%0d", req, act, lo);
        end
    endtask

    task automatic run_cmd(input logic [1:0] op, input logic [10:0] a, input logic [7:0] d,
                           input bit poke, output int lat, output logic [7:0] rd, output logic er);
        @(negedge clk);
        cmd_op = op; cmd_addr = a; cmd_wdata = d; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        lat = 0;
        while (!rsp_valid && lat < 20000) begin
            if (poke && lat == 3) begin
                check("R8 ready low while busy", int'(cmd_ready), 0);
                cmd_op = 2'b01; cmd_addr = 11'd200; cmd_wdata = 8'h11; cmd_valid = 1'b1;
            end
            if (poke && lat == 4) cmd_valid = 1'b0;
            @(negedge clk);
            lat++;
        end
        check("watchdog response", int'(rsp_valid), 1);
        rd = rsp_rdata; er = rsp_err;
        @(negedge clk);
        check("R9 single-cycle rsp", int'(rsp_valid), 0);
    endtask

    task automatic t_reset;
        check("R1 ready", int'(cmd_ready), 1);
        check("R1 ce_n", int'(mem_ce_n), 1);
        check("R1 oe_n", int'(mem_oe_n), 1);
        check("R1 we_n", int'(mem_we_n), 1);
        check("R1 dq_oe", int'(mem_dq_oe), 0);
        check("R1 hv_req", int'(mem_hv_req), 0);
        check("R1 rsp_valid", int'(rsp_valid), 0);
    endtask

    task automatic t_read(input logic [10:0] a, input logic [7:0] exp);
        int lat; logic [7:0] rd; logic er;
        run_cmd(2'b00, a, 8'h00, 0, lat, rd, er);
        check("R2 read latency", lat, N_RD + N_FLT);
        check("R2 read data", int'(rd), int'(exp));
        check("R2 read err", int'(er), 0);
    endtask

    task automatic t_write(input logic [10:0] a, input logic [7:0] d, input bit poke);
        int lat, r0; logic [7:0] rd; logic er;
        r0 = n_reads;
        run_cmd(2'b01, a, d, poke, lat, rd, er);
        check("R3 setup cycles", int'(last_setup >= N_AS), 1);
        check("R3 we low cycles", last_low, N_WP);
        check_ge("R3 hold cycles", last_hold, N_H);
        check("R5 write err", int'(er), 0);
        check("R5 polled byte", int'(rd), int'(d));
        check_ge("R5 poll reads", n_reads - r0, 2);
        check_ge("R5 write latency", lat, BUSY_CYC);
    endtask

    task automatic t_timeout;
        int lat; logic [7:0] rd; logic er;
        stuck = 1;
        run_cmd(2'b01, 11'd300, 8'h80, 0, lat, rd, er);
        check("R6 timeout err", int'(er), 1);
        check_ge("R6 timeout latency", lat, n_to);
        stuck = 0;
        repeat (BUSY_CYC + 20) @(negedge clk);
    endtask

    task automatic t_clear;
        int lat; logic [7:0] rd; logic er;
        run_cmd(2'b10, 11'd0, 8'h00, 0, lat, rd, er);
        check("R7 clear latency", lat, 2 * N_CS + n_cw);
        check("R7 clear err", int'(er), 0);
        check("R7 hv at we fall", int'(hv_at_fall), 1);
        check("R7 setup", last_setup, N_CS);
        check("R7 pulse", last_low, n_cw);
        check("R7 hold", last_hold, N_CS);
    endtask

    task automatic t_reserved;
        int lat, f0; logic [7:0] rd; logic er;
        f0 = n_ce_falls;
        run_cmd(2'b11, 11'd9, 8'h00, 0, lat, rd, er);
        check("R10 reserved latency", lat, 0);
        check("R10 reserved err", int'(er), 1);
        check("R10 no strobe", n_ce_falls - f0, 0);
    endtask

    initial begin
        n_cw = cyc(CLR_NS);
        n_to = cyc(POLL_NS);
        stuck = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_read(11'd5, 8'h05 ^ 8'h5A);
        t_read(11'd2047, 8'hFF ^ 8'h5A);
        t_write(11'd100, 8'h3C, 0);
        t_read(11'd100, 8'h3C);
        t_write(11'd7, 8'hC3, 1);
        t_read(11'd7, 8'hC3);
        t_read(11'd200, 8'(200) ^ 8'h5A);   // R8 offered write had no effect
        t_timeout();
        t_reserved();
        t_clear();
        t_read(11'd0, 8'hFF);
        t_read(11'd100, 8'hFF);
        t_read(11'd2047, 8'hFF);
        check("R4 dq driven with OE low", viol, 0);
        check_ge("R4 dq driven in writes", dq_seen, 1);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=expired expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule